// File: doc/BRIEF.md
# Serial Shift-Add Multiplier

This block multiplies two unsigned operands one multiplier bit at a time. It uses a single accumulator that is one bit wider than the product. A load places the multiplier in the low half and clears everything above it. The bit at the bottom of the accumulator then decides each step. When it is 1, the multiplicand is added into the upper part and a shift follows. When it is 0, the block only shifts. Each step moves the multiplier out at the bottom and the growing product down into the low bits.

Control has two parts. A small add/shift sequencer reacts to the start request and to the current multiplier bit. A separate step counter counts the shifts and raises a completion flag on the last one, so the sequencer stays the same size for any operand width. When the run finishes, a one-cycle done pulse appears. The product then stays on the output until the next start is accepted.

Top module: `shift_add_mult`

## Requirements
- R1: A synchronous reset puts the block in idle with `done` low and `product` all zeros.
- R2: A start seen in idle loads the multiplier into the low W accumulator bits and clears the upper W+1 bits, so multiplying by zero gives a zero product even right after a nonzero result.
- R3: When the current multiplier bit is 1, the multiplicand is added to the upper W accumulator bits and the (W+1)-bit sum, carry included, replaces the top W+1 bits; the add is followed by a shift in the next cycle.
- R4: A shift moves all 2W+1 accumulator bits one place toward the least significant end and fills the top bit with 0.
- R5: The step counter advances on every shift, stays below W, and flags completion on the W-th shift; the sequencer stops after that shift.
- R6: Counting the start edge as edge 1, `done` goes high after edge 1 + W + (number of 1 bits in the multiplier).
- R7: `done` is high for exactly one cycle; `product` (accumulator bits 2W-1..0) holds the result from then until the next start is accepted.
- R8: A start raised while an operation is running is ignored: neither the result nor the latency changes.
- R9: With W = 4, 13 × 11 gives 143 (1101 × 1011 = 10001111).
- R10: For every pair of W-bit unsigned operands, `product` equals their full 2W-bit product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication; used only in idle |
| mcand | input | W | Multiplicand, read at every add |
| mplier | input | W | Multiplier, captured at start |
| product | output | 2W | Low 2W accumulator bits; the result once done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with the default W = 4. At that width the whole space of 256 operand pairs can be swept exhaustively. The sweep reaches the largest carry (15 × 15), every popcount-dependent latency, and every add/shift order. Seeded random runs follow. Some of them pulse start in mid-operation, and some reuse a zero multiplier after a large product to show that the top bits are cleared at load.

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  localparam int AW = 2*W + 1;
  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {IDLE, TEST, SHIFT, FIN} st_t;

  st_t           st;
  logic [AW-1:0] acc;
  logic [CW-1:0] cnt;
  logic          ld, ad, sh, k;
  logic [W:0]    sum;

  assign k   = (cnt == CW'(W-1));
  assign ld  = (st == IDLE) && start;
  assign ad  = (st == TEST) && acc[0];
  assign sh  = ((st == TEST) && !acc[0]) || (st == SHIFT);
  assign sum = {1'b0, acc[2*W-1:W]} + {1'b0, mcand};

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (ld) acc <= {{(W+1){1'b0}}, mplier};
    else if (ad) acc <= {sum, acc[W-1:0]};
    else if (sh) acc <= {1'b0, acc[AW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst || ld) cnt <= '0;
    else if (sh)   cnt <= k ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= IDLE;
    else begin
      case (st)
        IDLE:    if (start) st <= TEST;
        TEST:    if (acc[0]) st <= SHIFT;
                 else if (k) st <= FIN;
        SHIFT:   st <= k ? FIN : TEST;
        default: st <= IDLE;
      endcase
    end
  end

  assign product = acc[2*W-1:0];
  assign done    = (st == FIN);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_LOAD_CLEARS_TOP: assert property (@(posedge clk) disable iff (rst)
    ld |=> (acc[AW-1:W] == '0 && cnt == '0)); // R2
  AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    ad |=> (st == SHIFT)); // R3
  AST_SHIFT_WHOLE: assert property (@(posedge clk) disable iff (rst)
    sh |=> (acc == {1'b0, $past(acc[AW-1:1])})); // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W-1)); // R5
  AST_FIN_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(k) && $past(sh))); // R5
  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == IDLE && !start) |=> $stable(product)); // R7
endmodule

// File: tb/shift_add_mult_tb.sv
module shift_add_mult_tb;
  localparam int W = 4;

  logic           clk = 0;
  logic           rst = 1;
  logic           start = 0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  shift_add_mult #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  function automatic logic [2*W-1:0] exp_prod(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] p = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) p = p + ({{W{1'b0}}, a} << i);
    return p;
  endfunction

  function automatic int exp_lat(logic [W-1:0] b);
    int n = 1 + W;
    for (int i = 0; i < W; i++) n += b[i];
    return n;
  endfunction

  task automatic check(string req, logic ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(logic [W-1:0] a, logic [W-1:0] b, bit poke, string req);
    int n;
    @(negedge clk);
    mcand = a; mplier = b; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin
        start = 1; mplier = ~b;
      end else if (poke) begin
        start = 0;
      end
    end
    start = 0;
    if (n >= 100) check("watchdog", 1'b0, n, exp_lat(b));
    check(req, product == exp_prod(a, b), product, exp_prod(a, b));
    check(poke ? "R8 latency" : "R6", n == exp_lat(b), n, exp_lat(b));
    @(negedge clk);
    check("R7 pulse", !done, done, 0);
    check("R7 hold", product == exp_prod(a, b), product, exp_prod(a, b));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 done", !done, done, 0);
    check("R1 product", product == '0, product, 0);
    rst = 0;

    run(4'd13, 4'd11, 0, "R9");
    run(4'd15, 4'd15, 0, "R3 carry");
    run(4'd15, 4'd0,  0, "R2 zero after big");
    run(4'd0,  4'd15, 0, "R10 zero mcand");
    run(4'd9,  4'd8,  0, "R4 R5 top bit");
    run(4'd7,  4'd5,  1, "R8");

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run(a[W-1:0], b[W-1:0], 0, "R10");

    for (int i = 0; i < 60; i++)
      run($urandom_range(15), $urandom_range(15), ($urandom_range(3) == 0), "R10 rand");

    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check("R1 reset again", product == '0 && !done, product, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule